// File: doc/BRIEF.md
# Dual Data Pointer Register Unit

This unit keeps two 16-bit external-memory data pointers and a one-bit pointer select register. All three sit on the processor's special-function-register (SFR) byte bus. The unit drives the external-memory address path with the pointer that is currently selected. Instruction decode issues three kinds of pointer operation: increment, load of a 16-bit immediate, and byte access over the SFR bus. Increment and load always act on the selected pointer. Byte accesses reach either pointer directly by address.

Adding one to the select register flips the active pointer. A block move can therefore keep its source address in one pointer and its destination in the other, and swap between them with a single instruction. Pointer 0 keeps the addresses of a standard single-pointer core, so code that never touches the select register behaves as before. The unit decodes only its own five SFR addresses. Every other address reads as zero and has no effect when written.

Top module: `dual_dptr_unit`

## Requirements
- R1: On reset (rst_n low), both pointers become 0000h and the select bit becomes 0. ext_addr then reads 0000h, and SFR reads of 82h to 86h return 00h.
- R2: An SFR write to 82h replaces bits 7:0 of pointer 0, and a write to 83h replaces bits 15:8. Reads of those addresses return the same bytes.
- R3: An SFR write to 84h replaces bits 7:0 of pointer 1, and a write to 85h replaces bits 15:8. Reads return the same bytes. Pointer 1 can be written whether or not it is active.
- R4: The select register is at 86h, and its bit 0 is the select bit (0 = pointer 0 active, 1 = pointer 1 active). Writes set bit 0 from data bit 0. Bits 7:1 ignore writes and read as zero.
- R5: A pulse on sel_inc adds one to the select register, which flips the active pointer.
- R6: ptr_inc adds one to the active pointer as a 16-bit value. The carry passes from the low byte into the high byte, FFFFh wraps to 0000h, and the inactive pointer is left unchanged.
- R7: ptr_load writes load_val into the active pointer only.
- R8: ext_addr always shows the active pointer's registered value. It changes on the clock edge that completes a write, increment, load or select change.
- R9: Pointer operations and the choice of pointer use the select bit held before the edge. When operations on the active pointer coincide, load wins over increment, and increment wins over an SFR byte write. sel_inc wins over a same-cycle SFR write to 86h.
- R10: An SFR read of any address outside 82h to 86h returns 00h, and sfr_rdata is 00h while sfr_rd is low. A write to any such address changes no pointer and does not change the select bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sfr_addr | input | 8 | SFR byte address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rd | input | 1 | SFR read enable |
| sfr_rdata | output | 8 | SFR read data (combinational, zero when not addressed) |
| ptr_inc | input | 1 | Increment the active pointer |
| ptr_load | input | 1 | Load load_val into the active pointer |
| load_val | input | 16 | 16-bit immediate for ptr_load |
| sel_inc | input | 1 | Increment the select register |
| ext_addr | output | 16 | Active pointer value for the external-memory address path |

## Verification
A table-driven sequence runs three kinds of traffic: byte writes and reads at each owned address, increments with and without low-byte carry and with full 16-bit wraparound, and immediate loads. Each step is mixed with select flips. Writing the inactive pointer and then flipping to it shows whether byte writes target a pointer by address or by select. Writing FEh and 03h to the select register tells a one-bit field apart from a wider one. Directed steps then drive operations together in one cycle, which exposes the priority order and the use of the select bit held before the edge. A reset in the middle of the run checks that every byte clears.

// File: rtl/dptr_pkg.sv
package dptr_pkg;

    // Kind of SFR access decoded from the byte address
    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_PTR_LO = 2'd1,
        ACC_PTR_HI = 2'd2,
        ACC_SEL    = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/dptr_sfr_decode.sv
module dptr_sfr_decode
    import dptr_pkg::*;
#(
    parameter int AW       = 8,
    parameter int NUM_PTR  = 2,
    parameter int PTR_BASE = 'h82,
    parameter int SEL_ADDR = 'h86,
    localparam int IDX_W   = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
    input  logic [AW-1:0]    addr,
    output logic             hit,
    output acc_kind_e        kind,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        kind = ACC_NONE;
        idx  = '0;
        for (int i = 0; i < NUM_PTR; i++) begin
            if (addr == AW'(PTR_BASE + 2*i)) begin
                kind = ACC_PTR_LO;
                idx  = IDX_W'(i);
            end
            if (addr == AW'(PTR_BASE + 2*i + 1)) begin
                kind = ACC_PTR_HI;
                idx  = IDX_W'(i);
            end
        end
        if (addr == AW'(SEL_ADDR)) begin
            kind = ACC_SEL;
        end
        hit = (kind != ACC_NONE);
    end

endmodule

// File: rtl/dptr_sel_reg.sv
module dptr_sel_reg #(
    parameter int IDX_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_inc,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wdata,
    output logic [IDX_W-1:0] sel_q
);

    typedef struct packed {
        logic [IDX_W-1:0] sel;
    } sel_state_t;

    sel_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (sel_inc) begin
            state_d.sel = state_q.sel + IDX_W'(1);
        end else if (wr_en) begin
            state_d.sel = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sel_q = state_q.sel;

    // R5 (also R9: increment wins over a same-cycle write)
    sel_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_inc |=> sel_q == $past(sel_q) + IDX_W'(1));

    // R4
    sel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel_inc) |=> sel_q == $past(wdata));

    // R4
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !sel_inc) |=> $stable(sel_q));

endmodule

// File: rtl/dptr_lane.sv
module dptr_lane #(
    parameter int DW      = 8,
    parameter int IDX_W   = 1,
    parameter int LANE_ID = 0,
    localparam int PW     = 2 * DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] sel,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [DW-1:0]    wdata,
    input  logic             ptr_inc,
    input  logic             ptr_load,
    input  logic [PW-1:0]    load_val,
    output logic [PW-1:0]    val_q
);

    typedef struct packed {
        logic [PW-1:0] val;
    } lane_state_t;

    lane_state_t state_d, state_q;
    logic        active;

    assign active = (sel == IDX_W'(LANE_ID));

    always_comb begin
        state_d = state_q;
        if (active && ptr_load) begin
            state_d.val = load_val;
        end else if (active && ptr_inc) begin
            state_d.val = state_q.val + PW'(1);
        end else if (wr_hi) begin
            state_d.val = {wdata, state_q.val[DW-1:0]};
        end else if (wr_lo) begin
            state_d.val = {state_q.val[PW-1:DW], wdata};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign val_q = state_q.val;

    // R7 (also R9: load wins)
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ptr_load) |=> val_q == $past(load_val));

    // R6 (also R9: increment wins over a byte write)
    inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ptr_inc && !ptr_load) |=> val_q == $past(val_q) + PW'(1));

    // R2
    lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !(active && (ptr_inc || ptr_load)))
        |=> (val_q[DW-1:0] == $past(wdata)) && (val_q[PW-1:DW] == $past(val_q[PW-1:DW])));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi && !(active && (ptr_inc || ptr_load))) |=> $stable(val_q));

endmodule

// File: rtl/dptr_bank.sv
module dptr_bank #(
    parameter int DW      = 8,
    parameter int NUM_PTR = 2,
    localparam int PW     = 2 * DW,
    localparam int IDX_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IDX_W-1:0]      sel,
    input  logic                  byte_wr,
    input  logic                  byte_hi,
    input  logic [IDX_W-1:0]      byte_idx,
    input  logic [DW-1:0]         wdata,
    input  logic                  ptr_inc,
    input  logic                  ptr_load,
    input  logic [PW-1:0]         load_val,
    output logic [NUM_PTR*PW-1:0] ptr_flat
);

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_lane
        logic target;
        assign target = byte_wr && (byte_idx == IDX_W'(g));

        dptr_lane #(
            .DW      (DW),
            .IDX_W   (IDX_W),
            .LANE_ID (g)
        ) i_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (sel),
            .wr_lo    (target && !byte_hi),
            .wr_hi    (target && byte_hi),
            .wdata    (wdata),
            .ptr_inc  (ptr_inc),
            .ptr_load (ptr_load),
            .load_val (load_val),
            .val_q    (ptr_flat[g*PW +: PW])
        );
    end

endmodule

// File: rtl/dual_dptr_unit.sv
module dual_dptr_unit
    import dptr_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DW       = 8,
    parameter int NUM_PTR  = 2,
    parameter int PTR_BASE = 'h82,
    parameter int SEL_ADDR = 'h86,
    localparam int PW      = 2 * DW,
    localparam int IDX_W   = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] sfr_addr,
    input  logic          sfr_wr,
    input  logic [DW-1:0] sfr_wdata,
    input  logic          sfr_rd,
    output logic [DW-1:0] sfr_rdata,
    input  logic          ptr_inc,
    input  logic          ptr_load,
    input  logic [PW-1:0] load_val,
    input  logic          sel_inc,
    output logic [PW-1:0] ext_addr
);

    acc_kind_e             acc_kind;
    logic [IDX_W-1:0]      acc_idx;
    logic                  acc_hit;
    logic [IDX_W-1:0]      sel_q;
    logic [NUM_PTR*PW-1:0] ptr_flat;
    logic [PW-1:0]         rd_ptr;

    dptr_sfr_decode #(
        .AW       (AW),
        .NUM_PTR  (NUM_PTR),
        .PTR_BASE (PTR_BASE),
        .SEL_ADDR (SEL_ADDR)
    ) i_decode (
        .addr (sfr_addr),
        .hit  (acc_hit),
        .kind (acc_kind),
        .idx  (acc_idx)
    );

    dptr_sel_reg #(
        .IDX_W (IDX_W)
    ) i_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_inc (sel_inc),
        .wr_en   (sfr_wr && (acc_kind == ACC_SEL)),
        .wdata   (sfr_wdata[IDX_W-1:0]),
        .sel_q   (sel_q)
    );

    dptr_bank #(
        .DW      (DW),
        .NUM_PTR (NUM_PTR)
    ) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel_q),
        .byte_wr  (sfr_wr && ((acc_kind == ACC_PTR_LO) || (acc_kind == ACC_PTR_HI))),
        .byte_hi  (acc_kind == ACC_PTR_HI),
        .byte_idx (acc_idx),
        .wdata    (sfr_wdata),
        .ptr_inc  (ptr_inc),
        .ptr_load (ptr_load),
        .load_val (load_val),
        .ptr_flat (ptr_flat)
    );

    assign rd_ptr   = ptr_flat[acc_idx*PW +: PW];
    assign ext_addr = ptr_flat[sel_q*PW +: PW];

    always_comb begin
        sfr_rdata = '0;
        if (sfr_rd) begin
            unique case (acc_kind)
                ACC_PTR_LO: sfr_rdata = rd_ptr[DW-1:0];
                ACC_PTR_HI: sfr_rdata = rd_ptr[PW-1:DW];
                ACC_SEL:    sfr_rdata = DW'(sel_q);
                default:    sfr_rdata = '0;
            endcase
        end
    end

    // R10
    foreign_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sfr_rd || !acc_hit) |-> sfr_rdata == '0);

    // R8
    ext_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_load && !sel_inc) |=> ext_addr == $past(load_val));

    // R8
    ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sfr_wr && !ptr_inc && !ptr_load && !sel_inc) |=> $stable(ext_addr));

endmodule

// File: tb/test_dual_dptr_unit.sv
`timescale 1ns/1ps
module test_dual_dptr_unit;

    localparam time PERIOD = 20ns;

    localparam logic [2:0] OP_WR = 3'd0, OP_INC = 3'd1, OP_LD = 3'd2,
                           OP_SEL = 3'd3, OP_RD = 3'd4;

    // {op[46:44], req[43:40], addr[39:32], data[31:16], expected[15:0]}
    // expected = ext_addr after the step, or {00h, rdata} for reads
    localparam int NVEC = 27;
    localparam logic [46:0] VEC [NVEC] = '{
        {OP_WR,  4'd2,  8'h82, 16'h0034, 16'h0034},  // R2
        {OP_WR,  4'd2,  8'h83, 16'h0012, 16'h1234},  // R2
        {OP_WR,  4'd3,  8'h84, 16'h00CD, 16'h1234},  // R3 inactive write
        {OP_WR,  4'd3,  8'h85, 16'h00AB, 16'h1234},  // R3
        {OP_RD,  4'd3,  8'h84, 16'h0000, 16'h00CD},  // R3
        {OP_RD,  4'd3,  8'h85, 16'h0000, 16'h00AB},  // R3
        {OP_SEL, 4'd5,  8'h00, 16'h0000, 16'hABCD},  // R5
        {OP_INC, 4'd6,  8'h00, 16'h0000, 16'hABCE},  // R6
        {OP_RD,  4'd4,  8'h86, 16'h0000, 16'h0001},  // R4
        {OP_WR,  4'd4,  8'h86, 16'h00FE, 16'h1234},  // R4 upper bits ignored
        {OP_RD,  4'd4,  8'h86, 16'h0000, 16'h0000},  // R4
        {OP_WR,  4'd3,  8'h85, 16'h00FF, 16'h1234},  // R3
        {OP_WR,  4'd3,  8'h84, 16'h00FF, 16'h1234},  // R3
        {OP_SEL, 4'd5,  8'h00, 16'h0000, 16'hFFFF},  // R5
        {OP_INC, 4'd6,  8'h00, 16'h0000, 16'h0000},  // R6 wrap
        {OP_RD,  4'd6,  8'h85, 16'h0000, 16'h0000},  // R6
        {OP_SEL, 4'd5,  8'h00, 16'h0000, 16'h1234},  // R5
        {OP_WR,  4'd2,  8'h82, 16'h00FF, 16'h12FF},  // R2
        {OP_INC, 4'd6,  8'h00, 16'h0000, 16'h1300},  // R6 carry
        {OP_LD,  4'd7,  8'h00, 16'h5A5A, 16'h5A5A},  // R7
        {OP_RD,  4'd7,  8'h84, 16'h0000, 16'h0000},  // R7 other untouched
        {OP_WR,  4'd10, 8'h90, 16'h0077, 16'h5A5A},  // R10
        {OP_RD,  4'd10, 8'h90, 16'h0000, 16'h0000},  // R10
        {OP_RD,  4'd2,  8'h82, 16'h0000, 16'h005A},  // R2
        {OP_WR,  4'd4,  8'h86, 16'h0003, 16'h0000},  // R4
        {OP_LD,  4'd8,  8'h00, 16'hBEEF, 16'hBEEF},  // R8
        {OP_SEL, 4'd8,  8'h00, 16'h0000, 16'h5A5A}   // R8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sfr_addr = '0;
    logic        sfr_wr = 1'b0;
    logic [7:0]  sfr_wdata = '0;
    logic        sfr_rd = 1'b0;
    logic [7:0]  sfr_rdata;
    logic        ptr_inc = 1'b0;
    logic        ptr_load = 1'b0;
    logic [15:0] load_val = '0;
    logic        sel_inc = 1'b0;
    logic [15:0] ext_addr;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [7:0]  rd_seen;

    always #(PERIOD/2) clk = ~clk;

    dual_dptr_unit i_dual_dptr_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .sfr_addr  (sfr_addr),
        .sfr_wr    (sfr_wr),
        .sfr_wdata (sfr_wdata),
        .sfr_rd    (sfr_rd),
        .sfr_rdata (sfr_rdata),
        .ptr_inc   (ptr_inc),
        .ptr_load  (ptr_load),
        .load_val  (load_val),
        .sel_inc   (sel_inc),
        .ext_addr  (ext_addr)
    );

    task automatic check(input int req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One cycle of stimulus; rdata captured mid-cycle, state observed after edge
    task automatic drive(input logic wr, input logic [7:0] addr, input logic [7:0] wd,
                         input logic inc, input logic ld, input logic [15:0] lv,
                         input logic si, input logic rd);
        @(negedge clk);
        sfr_wr = wr; sfr_addr = addr; sfr_wdata = wd; sfr_rd = rd;
        ptr_inc = inc; ptr_load = ld; load_val = lv; sel_inc = si;
        #2;
        rd_seen = sfr_rdata;
        @(posedge clk);
        #1;
        sfr_wr = 1'b0; sfr_rd = 1'b0; ptr_inc = 1'b0; ptr_load = 1'b0; sel_inc = 1'b0;
        #1;
    endtask

    task automatic read_chk(input int req, input logic [7:0] addr, input logic [7:0] exp);
        drive(1'b0, addr, 8'h00, 1'b0, 1'b0, 16'h0, 1'b0, 1'b1);
        check(req, $sformatf("read %h", addr), {8'h00, rd_seen}, {8'h00, exp});
    endtask

    initial begin
        #(PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(1, "ext_addr in reset", ext_addr, 16'h0000);
        rst_n = 1'b1;
        read_chk(1, 8'h83, 8'h00);
        read_chk(1, 8'h86, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            logic [2:0]  op;
            logic [3:0]  req;
            logic [7:0]  a;
            logic [15:0] d, e;
            {op, req, a, d, e} = VEC[i];
            case (op)
                OP_WR:  drive(1'b1, a, d[7:0], 1'b0, 1'b0, 16'h0, 1'b0, 1'b0);
                OP_INC: drive(1'b0, a, 8'h0, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0);
                OP_LD:  drive(1'b0, a, 8'h0, 1'b0, 1'b1, d, 1'b0, 1'b0);
                OP_SEL: drive(1'b0, a, 8'h0, 1'b0, 1'b0, 16'h0, 1'b1, 1'b0);
                default: drive(1'b0, a, 8'h0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b1);
            endcase
            if (op == OP_RD)
                check(int'(req), $sformatf("vec %0d rdata", i), {8'h00, rd_seen}, e);
            else
                check(int'(req), $sformatf("vec %0d ext_addr", i), ext_addr, e);
        end

        // State now: pointer 0 = 5A5Ah active, pointer 1 = BEEFh
        // R9: load beats increment and byte write
        drive(1'b1, 8'h82, 8'h99, 1'b1, 1'b1, 16'h1111, 1'b0, 1'b0);
        check(9, "load over inc and write", ext_addr, 16'h1111);
        // R9: increment beats byte write
        drive(1'b1, 8'h83, 8'h77, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0);
        check(9, "inc over write", ext_addr, 16'h1112);
        // R9: increment uses the select held before the edge
        drive(1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 16'h0, 1'b1, 1'b0);
        check(9, "inc with sel flip", ext_addr, 16'hBEEF);
        read_chk(9, 8'h82, 8'h13);
        // R9: sel_inc beats write to select register
        drive(1'b1, 8'h86, 8'h01, 1'b0, 1'b0, 16'h0, 1'b1, 1'b0);
        check(9, "sel_inc over write", ext_addr, 16'h1113);
        // R10: rdata zero while sfr_rd low even at owned address
        @(negedge clk);
        sfr_addr = 8'h82;
        #2;
        check(10, "rdata with rd low", {8'h00, sfr_rdata}, 16'h0000);

        // R1: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        check(1, "ext_addr after reset", ext_addr, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        read_chk(1, 8'h82, 8'h00);
        read_chk(1, 8'h84, 8'h00);
        read_chk(1, 8'h85, 8'h00);
        read_chk(1, 8'h86, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule